// File: doc/BRIEF.md
# Weighted Dual-Queue Transaction Scheduler

This block decides which logical DMA channel gets the next transaction on a single memory port. Each channel is started by a one-cycle activation pulse that also carries a priority bit. The pulse places the channel number in either a high-priority or a low-priority first-in first-out queue. When the port is free, the scheduler takes the channel at the head of one of the two queues and issues a one-cycle grant strobe that carries the channel number. Only one transaction is outstanding at a time.

When that transaction finishes, a completion report comes back with a flag that says whether the channel's whole transfer is done. If more work remains, the channel returns to the tail of the queue it came from. This gives first-come first-served service, one transaction at a time. If the transfer is done, the channel goes inactive.

An 8-bit rate value N sets how service is shared between the two queues. After N grants from the high queue, the next grant goes to the low queue. When one queue is empty, the other queue is served whatever the weighting state.

Top module: `txn_weighted_sched`

## Requirements
- R1: After reset, no channel is active, both queues are empty and `grant_valid` stays low until a channel has been activated.
- R2: An accepted activation of channel k appends k to the tail of the high queue when its `act_hi` bit is 1, and to the tail of the low queue when that bit is 0.
- R3: Activations in the same cycle are appended in ascending channel order. A completed channel being re-queued in that same cycle goes ahead of all of them.
- R4: A grant happens only in a cycle with `port_ready` high, no outstanding transaction and at least one queued channel. `grant_valid` then pulses high for exactly one cycle, in the following cycle. `grant_ch` shows the head of the chosen queue and holds that value until completion.
- R5: Let N be `arb_rate`, with 0 treated as 1. While both queues hold channels, the grant sequence is N from the high queue, then one from the low queue, repeating. A low grant restarts the count. High grants made while the low queue is empty also count, up to N.
- R6: When one queue is empty, the head of the other queue is granted regardless of the weighting count.
- R7: A completion with `done_last` = 0 appends the granted channel to the tail of the queue it was taken from.
- R8: A completion with `done_last` = 1 makes the channel inactive. It is never granted again unless it is activated again.
- R9: An activation pulse for a channel that is already active is ignored. This applies whether the channel is queued or granted, and also in the cycle of its final completion.
- R10: No second grant is issued before `done_valid` reports completion of the outstanding one. `done_valid` pulses are ignored while nothing is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_pulse | input | NUM_CH | One-cycle activation request per channel |
| act_hi | input | NUM_CH | Priority bit sampled with the activation (1 = high queue) |
| port_ready | input | 1 | Port can accept a new transaction |
| done_valid | input | 1 | Outstanding transaction has completed |
| done_last | input | 1 | With done_valid: the channel's transfer is finished |
| arb_rate | input | RATE_W | High-to-low weighting N (0 acts as 1) |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_ch | output | CH_W | Granted channel number |

## Verification
The bound checker checks these rules on every cycle:
- a grant always follows a cycle with the port ready and the scheduler idle;
- the strobe lasts one cycle and no grant appears while a transaction is outstanding;
- the non-empty queue is chosen when the other is empty;
- a retired channel is cleared while a re-queued one stays active;
- the number of active channels always equals the queued ones plus the outstanding one.

The exact grant order needs a reference queue model, which only the bench's scenarios provide. This covers the N-to-1 interleave for several rates, the ascending order of simultaneous activations, re-queue ahead of new arrivals, and the dropping of duplicate activations.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    QSEL_LO = 1'b0,
    QSEL_HI = 1'b1
  } qsel_e;
endpackage

// File: rtl/chq_fifo.sv
module chq_fifo #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push_req,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [NUM_CH-1:0] push_vec,
  output logic [CH_W-1:0]   head,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(NUM_CH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CH_W-1:0]  ent_q [NUM_CH];
  logic [CH_W-1:0]  ent_d [NUM_CH];
  logic [CH_W-1:0]  shft  [NUM_CH];
  logic [CNT_W-1:0] cnt_q, cnt_d, base, pos;
  logic             upd;

  // pop shifts the array toward the head; pushes then fill from the new tail
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) shft[i] = ent_q[i];
    base = cnt_q;
    if (pop) begin
      for (int i = 0; i < NUM_CH - 1; i++) shft[i] = ent_q[i + 1];
      shft[NUM_CH-1] = '0;
      base = cnt_q - ONE_C;
    end
    for (int i = 0; i < NUM_CH; i++) ent_d[i] = shft[i];
    pos = base;
    if (push_req) begin
      if (pos < DEPTH_C) ent_d[pos[CH_W-1:0]] = req_ch;
      pos = pos + ONE_C;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (push_vec[k]) begin
        if (pos < DEPTH_C) ent_d[pos[CH_W-1:0]] = CH_W'(k);
        pos = pos + ONE_C;
      end
    end
    cnt_d = pos;
    upd   = pop | push_req | (|push_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NUM_CH; i++) ent_q[i] <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      for (int i = 0; i < NUM_CH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign head  = ent_q[0];
  assign count = cnt_q;
endmodule

// File: rtl/rate_weigher.sv
module rate_weigher #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_avail,
  input  logic              lo_avail,
  input  logic [RATE_W-1:0] rate,
  input  logic              fire,
  output logic              pick_hi
);
  logic [RATE_W-1:0] run_q, run_d, n_eff;
  logic              below;

  always_comb begin
    n_eff   = (rate == '0) ? RATE_W'(1) : rate;
    below   = (run_q < n_eff);
    pick_hi = hi_avail && (!lo_avail || below);
    run_d   = run_q;
    if (pick_hi) begin
      if (below) run_d = run_q + RATE_W'(1);
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (fire) run_q <= run_d;
  end
endmodule

// File: rtl/chan_tracker.sv
module chan_tracker #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act_pulse,
  input  logic              retire,
  input  logic [CH_W-1:0]   retire_ch,
  output logic [NUM_CH-1:0] accept,
  output logic [NUM_CH-1:0] active
);
  logic [NUM_CH-1:0] act_q, act_d;
  logic              upd;

  always_comb begin
    accept = act_pulse & ~act_q;
    act_d  = act_q | accept;
    if (retire) act_d[retire_ch] = 1'b0;
    upd = (|accept) | retire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   act_q <= '0;
    else if (upd) act_q <= act_d;
  end

  assign active = act_q;
endmodule

// File: rtl/txn_weighted_sched.sv
module txn_weighted_sched #(
  parameter int NUM_CH = 16,
  parameter int RATE_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act_pulse,
  input  logic [NUM_CH-1:0] act_hi,
  input  logic              port_ready,
  input  logic              done_valid,
  input  logic              done_last,
  input  logic [RATE_W-1:0] arb_rate,
  output logic              grant_valid,
  output logic [CH_W-1:0]   grant_ch
);
  import sched_pkg::*;

  logic [CNT_W-1:0]  hi_cnt, lo_cnt;
  logic [CH_W-1:0]   hi_head, lo_head;
  logic [NUM_CH-1:0] accept, active;
  logic              busy_q, busy_d, gv_q, gv_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  qsel_e             src_q, src_d;
  logic              fire, pick_hi, finish, requeue, retire;
  logic              pop_hi, pop_lo, rq_hi, rq_lo, reg_en;

  // grant decision and completion handling
  always_comb begin
    fire    = !busy_q && port_ready && ((hi_cnt != '0) || (lo_cnt != '0));
    pop_hi  = fire && pick_hi;
    pop_lo  = fire && !pick_hi;
    finish  = busy_q && done_valid;
    requeue = finish && !done_last;
    retire  = finish && done_last;
    rq_hi   = requeue && (src_q == QSEL_HI);
    rq_lo   = requeue && (src_q == QSEL_LO);
  end

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    src_d  = src_q;
    gv_d   = fire;
    if (fire) begin
      busy_d = 1'b1;
      ch_d   = pick_hi ? hi_head : lo_head;
      src_d  = pick_hi ? QSEL_HI : QSEL_LO;
    end else if (finish) begin
      busy_d = 1'b0;
    end
    reg_en = fire | finish | gv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gv_q   <= 1'b0;
      ch_q   <= '0;
      src_q  <= QSEL_LO;
    end else if (reg_en) begin
      busy_q <= busy_d;
      gv_q   <= gv_d;
      ch_q   <= ch_d;
      src_q  <= src_d;
    end
  end

  chan_tracker #(.NUM_CH(NUM_CH)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_pulse (act_pulse),
    .retire    (retire),
    .retire_ch (ch_q),
    .accept    (accept),
    .active    (active)
  );

  chq_fifo #(.NUM_CH(NUM_CH)) hiq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (pop_hi),
    .push_req (rq_hi),
    .req_ch   (ch_q),
    .push_vec (accept & act_hi),
    .head     (hi_head),
    .count    (hi_cnt)
  );

  chq_fifo #(.NUM_CH(NUM_CH)) loq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (pop_lo),
    .push_req (rq_lo),
    .req_ch   (ch_q),
    .push_vec (accept & ~act_hi),
    .head     (lo_head),
    .count    (lo_cnt)
  );

  rate_weigher #(.RATE_W(RATE_W)) weigh_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_avail (hi_cnt != '0),
    .lo_avail (lo_cnt != '0),
    .rate     (arb_rate),
    .fire     (fire),
    .pick_hi  (pick_hi)
  );

  assign grant_valid = gv_q;
  assign grant_ch    = ch_q;
endmodule

// File: rtl/txn_sched_chk.sv
module txn_sched_chk #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_ready,
  input logic              done_valid,
  input logic              done_last,
  input logic              grant_valid,
  input logic [CH_W-1:0]   grant_ch,
  input logic              busy,
  input logic              from_hi,
  input logic [CNT_W-1:0]  hi_cnt,
  input logic [CNT_W-1:0]  lo_cnt,
  input logic [NUM_CH-1:0] active
);
  // R4
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ($past(port_ready) && !$past(busy)));

  // R4
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> !grant_valid);

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_valid) |=> !grant_valid);

  // R6
  lo_empty_serve_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && port_ready && lo_cnt == '0 && hi_cnt != '0) |=> (grant_valid && from_hi));

  // R6
  hi_empty_serve_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && port_ready && hi_cnt == '0 && lo_cnt != '0) |=> (grant_valid && !from_hi));

  // R8
  retire_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_valid && done_last) |=> !active[$past(grant_ch)]);

  // R7
  requeue_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_valid && !done_last) |=> active[$past(grant_ch)]);

  // R9
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) == (int'(hi_cnt) + int'(lo_cnt) + int'(busy)));
endmodule

bind txn_weighted_sched txn_sched_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_ready  (port_ready),
  .done_valid  (done_valid),
  .done_last   (done_last),
  .grant_valid (grant_valid),
  .grant_ch    (grant_ch),
  .busy        (busy_q),
  .from_hi     (src_q),
  .hi_cnt      (hi_cnt),
  .lo_cnt      (lo_cnt),
  .active      (active)
);

// File: tb/txn_weighted_sched_tb_top.sv
`timescale 1ns/1ps
module txn_weighted_sched_tb_top;
  localparam int NUM_CH = 16;
  localparam int RATE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_CH-1:0] act_pulse, act_hi;
  logic              port_ready, done_valid, done_last;
  logic [RATE_W-1:0] arb_rate;
  logic              grant_valid;
  logic [3:0]        grant_ch;

  always #2.5 clk = ~clk;

  txn_weighted_sched #(.NUM_CH(NUM_CH), .RATE_W(RATE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_pulse(act_pulse), .act_hi(act_hi),
    .port_ready(port_ready), .done_valid(done_valid), .done_last(done_last),
    .arb_rate(arb_rate), .grant_valid(grant_valid), .grant_ch(grant_ch)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    finished = 0;
  bit    auto_done = 1;
  int    last_pct = 100;
  bit    stray = 0;

  // reference model state
  bit          m_busy, m_hi, e_gv;
  int          m_cur, m_cnt, e_gch;
  bit [NUM_CH-1:0] m_active;
  int          hq[$], lq[$];

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    int  n = (arb_rate == 0) ? 1 : int'(arb_rate);
    bit  ob = m_busy;
    bit [NUM_CH-1:0] oa = m_active;
    bit  ph;
    e_gv = 0;
    if (!ob && port_ready && (hq.size() + lq.size() > 0)) begin
      ph = (hq.size() > 0) && (lq.size() == 0 || m_cnt < n);
      if (ph) begin m_cur = hq.pop_front(); if (m_cnt < n) m_cnt++; end
      else    begin m_cur = lq.pop_front(); m_cnt = 0; end
      m_hi = ph; m_busy = 1; e_gv = 1; e_gch = m_cur;
    end
    if (ob && done_valid) begin
      if (!done_last) begin
        if (m_hi) hq.push_back(m_cur); else lq.push_back(m_cur);
      end else m_active[m_cur] = 0;
      m_busy = 0;
    end
    for (int k = 0; k < NUM_CH; k++)
      if (act_pulse[k] && !oa[k]) begin
        m_active[k] = 1;
        if (act_hi[k]) hq.push_back(k); else lq.push_back(k);
      end
  endtask

  // one clock: choose completion, step model, check outputs after the edge
  task automatic cyc();
    if (m_busy && auto_done) begin
      done_valid = 1'b1;
      done_last  = (int'($urandom_range(99)) < last_pct);
    end else if (!m_busy && stray) begin
      done_valid = $urandom_range(1);
      done_last  = $urandom_range(1);
    end
    model_step();
    @(negedge clk);
    chk(grant_valid === e_gv, "grant_valid", int'(grant_valid), int'(e_gv));
    if (e_gv) chk(int'(grant_ch) == e_gch, "grant_ch", int'(grant_ch), e_gch);
    act_pulse = '0; act_hi = '0; done_valid = 0; done_last = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic drain();
    port_ready = 1; auto_done = 1; last_pct = 100;
    run(80);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; act_pulse = '0; act_hi = '0; port_ready = 0;
    done_valid = 0; done_last = 0; arb_rate = 8'd2;
    m_busy = 0; m_hi = 0; m_cur = 0; m_cnt = 0; m_active = '0; e_gv = 0; e_gch = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(grant_valid === 1'b0, "grant_valid in reset", int'(grant_valid), 0);
    rst_n = 1;
    port_ready = 1;
    run(5);

    // R2 / R4: queue placement, no grant while port busy
    tag = "R2";
    port_ready = 0;
    act_pulse[3] = 1; act_hi[3] = 1; act_pulse[7] = 1; act_hi[7] = 0;
    cyc();
    tag = "R4";
    run(3);
    port_ready = 1; run(10);

    // R3: simultaneous activations in ascending order
    tag = "R3";
    port_ready = 0; arb_rate = 8'd255;
    act_pulse = '1; act_hi = '0;
    cyc();
    port_ready = 1; run(40);
    // R3: requeue ahead of new arrival in same cycle
    last_pct = 0; act_pulse[2] = 1; act_hi[2] = 0; cyc();
    run(2); act_pulse[9] = 1; act_hi[9] = 0; cyc();
    run(6);
    drain();

    // R5: N-to-1 weighting for several rates
    tag = "R5";
    arb_rate = 8'd3; last_pct = 0;
    for (int k = 0; k < 4; k++) begin act_pulse[k] = 1; act_hi[k] = 1; end
    act_pulse[8] = 1; act_pulse[9] = 1;
    cyc(); run(60);
    arb_rate = 8'd0; run(30);
    arb_rate = 8'd1; run(20);
    drain();

    // R6: only one queue populated
    tag = "R6";
    arb_rate = 8'd1; last_pct = 0;
    act_pulse[1] = 1; act_hi[1] = 1; act_pulse[2] = 1; act_hi[2] = 1;
    cyc(); run(20);
    drain();

    // R7: lone low channel keeps coming back
    tag = "R7";
    last_pct = 0; act_pulse[4] = 1; act_hi[4] = 0;
    cyc(); run(12);
    drain();

    // R9: duplicate activations dropped
    tag = "R9";
    port_ready = 0;
    act_pulse[5] = 1; act_hi[5] = 1; cyc();
    act_pulse[5] = 1; act_hi[5] = 0; cyc();
    act_pulse[5] = 1; cyc();
    port_ready = 1; auto_done = 0; run(2);
    act_pulse[5] = 1; cyc();
    auto_done = 1; last_pct = 100; run(6);

    // R10: no second grant before completion, idle completions ignored
    tag = "R10";
    auto_done = 0;
    act_pulse[6] = 1; act_hi[6] = 1; act_pulse[7] = 1; act_hi[7] = 1;
    cyc(); run(6);
    auto_done = 1; last_pct = 0; run(4);
    last_pct = 100; run(10);
    stray = 1; auto_done = 0; run(10);
    stray = 0; auto_done = 1;

    // R8: retired channels never come back
    tag = "R8";
    drain();
    chk(m_active == '0, "model idle", int'(m_active), 0);
    run(10);

    // mixed random traffic (R2 R3 R5 R7 R9 R10)
    tag = "RAND";
    last_pct = 30;
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < NUM_CH; k++)
        if ($urandom_range(99) < 4) begin
          act_pulse[k] = 1; act_hi[k] = $urandom_range(1);
        end
      port_ready = ($urandom_range(3) != 0);
      stray = ($urandom_range(7) == 0);
      if ($urandom_range(199) == 0) begin
        case ($urandom_range(4))
          0: arb_rate = 8'd0;
          1: arb_rate = 8'd1;
          2: arb_rate = 8'd2;
          3: arb_rate = 8'd255;
          default: arb_rate = 8'($urandom_range(255));
        endcase
      end
      cyc();
    end
    stray = 0; tag = "R8";
    drain(); drain();
    chk(m_active == '0, "all retired", int'(m_active), 0);
    run(10);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule